// File: doc/BRIEF.md
# Management-Interface Status Slave

This block is the serial management slave of an Ethernet PHY. It watches the management clock and data pins, decodes read and write frames that carry its strap address, and answers reads with a 16-bit status word. Part of that word is fixed capability flags. The rest is event bits that latch on link, remote-fault and jabber conditions, and a flag that tracks autonegotiation progress. A small control register is also present. Writing its restart bit produces a one-cycle autonegotiation-restart pulse.

The management clock `mdc` is sampled in the `clk` domain. The caller must supply `mdc` already synchronised to `clk`, with each half period lasting at least two `clk` cycles. Frames may start with a run of ones, or they may begin directly with the start pattern. The serial path has no back-pressure: the master sets the pace, and the slave responds whenever a frame addresses it. All event inputs are level signals sampled on `clk`.

Top module: `mdio_status_slave`

## Requirements
- R1: A frame is start `01`, a 2-bit opcode (`10` read, `01` write), a 5-bit PHY address and a 5-bit register address, all MSB first, then 2 turnaround bits and 16 data bits, MSB first. `mdio_in` is sampled on each rising edge of `mdc`. Any number of leading ones, including none, is accepted.
- R2: On a read, the slave releases the line (`mdio_oe`=0) during the first turnaround bit. It drives 0 during the second, then drives data bits 15 down to 0, each updated after a rising edge. It releases the line after the last data bit. After reset, `mdio_oe` and `an_restart` are 0.
- R3: `mdio_oe` rises only for read frames whose PHY address equals `phy_addr`. A frame with any other address has no effect, including no clearing of latched bits.
- R4: Status bit 15 reads 0. Bits 14..11 read 1. Bits 10..7 read 0. Bits 6, 3 and 0 read 1.
- R5: Status bit 5 resets to 0. It is cleared while `an_start` is high, which takes priority, and is set by `an_done`. Reads do not clear it.
- R6: Status bit 4 resets to 0 and is set by `remote_fault`. It clears on a read of register 1, unless `remote_fault` is high in the clear cycle.
- R7: Status bit 2 resets to 0 and is cleared while `link_up` is low. It returns to `link_up` only through a read of register 1, even if the link recovers before that read.
- R8: Status bit 1 is set by `jabber`. It clears only once register 1 has been read while the bit was set and `jabber` is low.
- R9: A read of register 1 returns the latched values as they were before that read's clear.
- R10: A read of any register address other than 0 or 1 returns 0x0000. A write to register 1 changes nothing.
- R11: A write to register 0 stores the data with bit 9 read back as 0. If bit 9 is 1, `an_restart` pulses high for exactly one `clk` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock, synchronous to `clk` |
| mdio_in | input | 1 | Management data from the bus |
| mdio_out | output | 1 | Management data driven by the slave |
| mdio_oe | output | 1 | High while the slave drives the bus |
| phy_addr | input | 5 | PHY address strap |
| link_up | input | 1 | Current link state |
| remote_fault | input | 1 | Remote fault seen |
| jabber | input | 1 | Jabber condition present |
| an_start | input | 1 | Autonegotiation started |
| an_done | input | 1 | Autonegotiation finished |
| an_restart | output | 1 | One-cycle autonegotiation-restart request |

## Verification
The hardest situation to reach is an event that coincides with a clear. One case is remote fault or jabber high in the exact cycle a status read clears the latches. The other is jabber being read while present and only later going away. The bench holds the event lines steady across whole read frames, so the clear cycle always sees them. It then drops jabber between reads to reach the deferred clear.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  localparam int OP_W   = 2;

  localparam logic [OP_W-1:0] OP_READ  = 2'b10;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

  localparam int CTRL_RESTART_BIT = 9;

  localparam int ST_AN   = 5;
  localparam int ST_RF   = 4;
  localparam int ST_LINK = 2;
  localparam int ST_JAB  = 1;

  // capability bits that never change: 14..11, 6, 3, 0
  localparam logic [DATA_W-1:0] STAT_FIXED = 16'h7849;

  typedef enum logic [2:0] {FR_IDLE, FR_START, FR_HDR, FR_TA, FR_DATA} frame_st_e;
endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mdc,
  input  logic          mdio_in,
  input  logic [AW-1:0] phy_addr,
  input  logic [DW-1:0] rd_data,
  output logic          mdio_out,
  output logic          mdio_oe,
  output logic          rd_req,
  output logic [AW-1:0] req_addr,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int HW = OP_W + 2 * AW;
  localparam int CW = $clog2(DW > HW ? DW : HW);
  localparam logic [CW-1:0] HDR_LAST  = CW'(HW - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DW - 1);
  localparam logic [CW-1:0] TA_LAST   = CW'(1);

  frame_st_e       st_q;
  logic [CW-1:0]   cnt_q;
  logic [HW-2:0]   hdr_q;
  logic [DW-1:0]   sh_q;
  logic [AW-1:0]   reg_q;
  logic            mdc_q, is_rd_q, is_wr_q;

  logic            mdc_rise, hdr_end, match;
  logic [HW-1:0]   hdr_nx;
  logic [OP_W-1:0] op_nx;

  assign mdc_rise = mdc & ~mdc_q;
  assign hdr_nx   = {hdr_q, mdio_in};
  assign op_nx    = hdr_nx[HW-1 -: OP_W];
  assign match    = (hdr_nx[2*AW-1 -: AW] == phy_addr);
  assign hdr_end  = mdc_rise && (st_q == FR_HDR) && (cnt_q == HDR_LAST);

  assign rd_req   = hdr_end && (op_nx == OP_READ) && match;
  assign req_addr = hdr_nx[AW-1:0];

  assign wr_stb   = mdc_rise && (st_q == FR_DATA) && (cnt_q == DATA_LAST) && is_wr_q;
  assign wr_addr  = reg_q;
  assign wr_data  = {sh_q[DW-2:0], mdio_in};

  assign mdio_oe  = is_rd_q && (((st_q == FR_TA) && (cnt_q == TA_LAST)) || (st_q == FR_DATA));
  assign mdio_out = (st_q == FR_DATA) ? sh_q[DW-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FR_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      sh_q    <= '0;
      reg_q   <= '0;
      mdc_q   <= 1'b0;
      is_rd_q <= 1'b0;
      is_wr_q <= 1'b0;
    end else begin
      mdc_q <= mdc;
      if (mdc_rise) begin
        case (st_q)
          FR_IDLE:  if (!mdio_in) st_q <= FR_START;
          FR_START: if (mdio_in) begin
                      st_q  <= FR_HDR;
                      cnt_q <= '0;
                    end
          FR_HDR: begin
            hdr_q <= hdr_nx[HW-2:0];
            cnt_q <= cnt_q + 1'b1;
            if (hdr_end) begin
              st_q    <= FR_TA;
              cnt_q   <= '0;
              reg_q   <= hdr_nx[AW-1:0];
              is_rd_q <= (op_nx == OP_READ) && match;
              is_wr_q <= (op_nx == OP_WRITE) && match;
              if (rd_req) sh_q <= rd_data;
            end
          end
          FR_TA: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == TA_LAST) begin
              st_q  <= FR_DATA;
              cnt_q <= '0;
            end
          end
          FR_DATA: begin
            sh_q  <= {sh_q[DW-2:0], mdio_in};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == DATA_LAST) begin
              st_q    <= FR_IDLE;
              is_rd_q <= 1'b0;
              is_wr_q <= 1'b0;
            end
          end
          default: st_q <= FR_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_stat_latch.sv
module mdio_stat_latch
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              remote_fault,
  input  logic              jabber,
  input  logic              an_start,
  input  logic              an_done,
  input  logic              clr,
  output logic [DATA_W-1:0] status
);
  logic link_q, rf_q, jab_q, jab_pend_q, an_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q     <= 1'b0;
      rf_q       <= 1'b0;
      jab_q      <= 1'b0;
      jab_pend_q <= 1'b0;
      an_q       <= 1'b0;
    end else begin
      // link latches low; only a read lets it follow the input again
      if (!link_up)  link_q <= 1'b0;
      else if (clr)  link_q <= 1'b1;

      // remote fault latches high; a new event beats the clear
      if (remote_fault) rf_q <= 1'b1;
      else if (clr)     rf_q <= 1'b0;

      // jabber clears once it was read and the condition has gone
      if (jabber) begin
        jab_q <= 1'b1;
        if (clr && jab_q) jab_pend_q <= 1'b1;
      end else if (jab_q && (jab_pend_q || clr)) begin
        jab_q      <= 1'b0;
        jab_pend_q <= 1'b0;
      end

      if (an_start)     an_q <= 1'b0;
      else if (an_done) an_q <= 1'b1;
    end
  end

  always_comb begin
    status          = STAT_FIXED;
    status[ST_AN]   = an_q;
    status[ST_RF]   = rf_q;
    status[ST_LINK] = link_q;
    status[ST_JAB]  = jab_q;
  end
endmodule

// File: rtl/mdio_status_slave.sv
module mdio_status_slave
  import mdio_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mdc,
  input  logic          mdio_in,
  output logic          mdio_out,
  output logic          mdio_oe,
  input  logic [AW-1:0] phy_addr,
  input  logic          link_up,
  input  logic          remote_fault,
  input  logic          jabber,
  input  logic          an_start,
  input  logic          an_done,
  output logic          an_restart
);
  localparam logic [AW-1:0] REG_CTRL = AW'(0);
  localparam logic [AW-1:0] REG_STAT = AW'(1);

  logic              rd_req, wr_stb, rd_clr, ctrl_wr;
  logic [AW-1:0]     req_addr, wr_addr;
  logic [DATA_W-1:0] wr_data, rd_data, status_word, ctrl_q;

  mdio_frame_fsm #(.AW(AW), .DW(DATA_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_in  (mdio_in),
    .phy_addr (phy_addr),
    .rd_data  (rd_data),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .rd_req   (rd_req),
    .req_addr (req_addr),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  assign rd_clr  = rd_req && (req_addr == REG_STAT);
  assign ctrl_wr = wr_stb && (wr_addr == REG_CTRL);

  mdio_stat_latch u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_up      (link_up),
    .remote_fault (remote_fault),
    .jabber       (jabber),
    .an_start     (an_start),
    .an_done      (an_done),
    .clr          (rd_clr),
    .status       (status_word)
  );

  always_comb begin
    case (req_addr)
      REG_CTRL: rd_data = ctrl_q;
      REG_STAT: rd_data = status_word;
      default:  rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      an_restart <= 1'b0;
    end else begin
      an_restart <= ctrl_wr && wr_data[CTRL_RESTART_BIT];
      if (ctrl_wr) begin
        ctrl_q                   <= wr_data;
        ctrl_q[CTRL_RESTART_BIT] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_slave_chk.sv
module mdio_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic        link_up,
  input logic        remote_fault,
  input logic        jabber,
  input logic        an_start,
  input logic        an_restart,
  input logic        rd_clr,
  input logic [15:0] status
);
  // R2: the first driven turnaround bit is a zero
  a_r2_ta_drive_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && !$past(mdio_oe)) |-> !mdio_out);

  // R5
  a_r5_an_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    an_start |=> !status[5]);

  // R6
  a_r6_rf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    remote_fault |=> status[4]);
  a_r6_rf_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !rd_clr) |=> status[4]);

  // R7
  a_r7_link_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> !status[2]);
  a_r7_link_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[2] && !rd_clr) |=> !status[2]);

  // R8
  a_r8_jab_sets: assert property (@(posedge clk) disable iff (!rst_n)
    jabber |=> status[1]);
  a_r8_jab_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && jabber) |=> status[1]);

  // R11
  a_r11_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |=> !an_restart);
endmodule

bind mdio_status_slave mdio_slave_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mdio_out     (mdio_out),
  .mdio_oe      (mdio_oe),
  .link_up      (link_up),
  .remote_fault (remote_fault),
  .jabber       (jabber),
  .an_start     (an_start),
  .an_restart   (an_restart),
  .rd_clr       (rd_clr),
  .status       (status_word)
);

// File: tb/tb_mdio_status_slave.sv
`timescale 1ns/1ps
module tb_mdio_status_slave;
  logic       clk = 1'b0, rst_n = 1'b0, mdc = 1'b0, mdio_in = 1'b1;
  logic [4:0] strap = 5'd9;
  logic       link_up = 1'b1, remote_fault = 1'b0, jabber = 1'b0, an_start = 1'b0, an_done = 1'b0;
  logic       mdio_out, mdio_oe, an_restart;

  mdio_status_slave dut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_in),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .phy_addr(strap),
    .link_up(link_up), .remote_fault(remote_fault), .jabber(jabber),
    .an_start(an_start), .an_done(an_done), .an_restart(an_restart)
  );

  always #2.5 clk = ~clk;

  int  n_checks = 0, n_fail = 0;
  bit  finished = 0;

  // behavioural reference state
  bit          m_link, m_rf, m_jab, m_pend, m_an, m_clr, jab_old;
  logic [15:0] m_ctl;
  bit          exp_oe = 0, exp_rst = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_link = 0; m_rf = 0; m_jab = 0; m_pend = 0; m_an = 0; m_clr = 0; m_ctl = 16'h0;
    end else begin
      jab_old = m_jab;
      if (!link_up) m_link = 0; else if (m_clr) m_link = 1;
      if (remote_fault) m_rf = 1; else if (m_clr) m_rf = 0;
      if (jabber) begin
        m_jab = 1;
        if (m_clr && jab_old) m_pend = 1;
      end else if (jab_old && (m_pend || m_clr)) begin
        m_jab = 0; m_pend = 0;
      end
      if (an_start) m_an = 0; else if (an_done) m_an = 1;
      m_clr = 0;
    end
  end

  function automatic logic [15:0] model_stat();
    return {1'b0, 4'b1111, 4'b0000, 1'b1, m_an, m_rf, 1'b1, m_link, m_jab, 1'b1};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // compared on every clock
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      #1;
      chk("R3 mdio_oe per clock", {15'd0, mdio_oe}, {15'd0, exp_oe});
      chk("R11 an_restart per clock", {15'd0, an_restart}, {15'd0, exp_rst});
    end
  end

  task automatic frame(input bit pre, input logic [1:0] op, input logic [4:0] pa,
                       input logic [4:0] ra, input logic [15:0] wd, input string tag);
    bit          is_rd, is_wr;
    logic [31:0] fb;
    logic [15:0] rd, exp_rd;
    logic        s;
    is_rd  = (op == 2'b10) && (pa == strap);
    is_wr  = (op == 2'b01) && (pa == strap);
    fb     = {2'b01, op, pa, ra, (op == 2'b10) ? 2'b11 : 2'b10, (op == 2'b10) ? 16'hFFFF : wd};
    rd     = '0;
    exp_rd = '0;
    if (pre) begin
      for (int i = 0; i < 32; i++) begin
        @(negedge clk) mdc = 0; mdio_in = 1;
        @(negedge clk); @(negedge clk);
        mdc = 1;
        @(negedge clk); @(negedge clk);
      end
    end
    for (int k = 0; k < 32; k++) begin
      @(negedge clk) mdc = 0; mdio_in = fb[31-k];
      @(negedge clk); @(negedge clk);
      s = mdio_oe ? mdio_out : 1'b1;
      if (k >= 16) rd[31-k] = s;
      if (k == 15 && is_rd) chk({"R2 turnaround zero ", tag}, {15'd0, s}, 16'd0);
      if (k == 13 && is_rd) begin
        exp_rd = (ra == 5'd1) ? model_stat() : (ra == 5'd0) ? m_ctl : 16'h0;
        if (ra == 5'd1) m_clr = 1;
      end
      mdc = 1;
      @(negedge clk);
      exp_oe = is_rd && (k >= 14) && (k <= 30);
      if (k == 31 && is_wr && ra == 5'd0) begin
        exp_rst = wd[9];
        m_ctl   = wd & 16'hFDFF;
      end
      @(negedge clk);
      exp_rst = 0;
    end
    @(negedge clk) mdc = 0; mdio_in = 1;
    if (is_rd) chk(tag, rd, exp_rd);
  endtask

  task automatic rd_stat(input bit pre, input string tag);
    frame(pre, 2'b10, strap, 5'd1, 16'h0, tag);
  endtask

  task automatic pulse_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R2 reset mdio_oe", {15'd0, mdio_oe}, 16'd0);
    chk("R11 reset an_restart", {15'd0, an_restart}, 16'd0);
    rst_n = 1;
    pulse_cycles(3);

    // R4 R7 R9: first read shows link latched low from reset, no preamble
    rd_stat(0, "R4 R7 R9 first status read");
    rd_stat(1, "R1 R7 read with preamble, link now up");

    // R6 single pulse
    @(negedge clk) remote_fault = 1; @(negedge clk) remote_fault = 0;
    rd_stat(0, "R6 rf latched");
    rd_stat(0, "R6 rf cleared");
    // R6 priority over clear
    @(negedge clk) remote_fault = 1;
    rd_stat(0, "R6 rf held during read");
    rd_stat(0, "R6 rf survives clear while present");
    @(negedge clk) remote_fault = 0;
    rd_stat(0, "R6 rf after release still latched");
    rd_stat(0, "R6 rf finally cleared");

    // R7 link flap recovers before read
    @(negedge clk) link_up = 0; pulse_cycles(4); link_up = 1;
    rd_stat(0, "R7 link latched low after recovery");
    rd_stat(0, "R7 link back after read");

    // R8 jabber
    @(negedge clk) jabber = 1; pulse_cycles(2);
    rd_stat(0, "R8 jabber seen");
    rd_stat(0, "R8 jabber kept while present");
    @(negedge clk) jabber = 0; pulse_cycles(2);
    rd_stat(0, "R8 jabber cleared after read and removal");
    @(negedge clk) jabber = 1; @(negedge clk) jabber = 0;
    rd_stat(1, "R8 jabber latched without read");
    rd_stat(0, "R8 jabber cleared by read");

    // R5 autonegotiation
    @(negedge clk) an_done = 1; @(negedge clk) an_done = 0;
    rd_stat(0, "R5 an complete set");
    rd_stat(0, "R5 an complete not read-cleared");
    @(negedge clk) an_start = 1; @(negedge clk) an_start = 0;
    rd_stat(0, "R5 an complete cleared by start");

    // R3 foreign address: no drive, no clear
    @(negedge clk) remote_fault = 1; @(negedge clk) remote_fault = 0;
    frame(0, 2'b10, 5'd3, 5'd1, 16'h0, "R3 foreign read");
    rd_stat(0, "R3 rf not cleared by foreign read");

    // R10
    frame(0, 2'b01, strap, 5'd1, 16'h0000, "R10 write reg1");
    rd_stat(0, "R10 status unchanged by write");
    frame(0, 2'b10, strap, 5'd7, 16'h0, "R10 unimplemented read");

    // R11
    frame(0, 2'b01, strap, 5'd0, 16'h1200, "R11 write restart");
    frame(0, 2'b10, strap, 5'd0, 16'h0, "R11 ctrl readback bit9 zero");
    frame(1, 2'b01, strap, 5'd0, 16'h0140, "R11 write no restart");
    frame(0, 2'b10, strap, 5'd0, 16'h0, "R11 ctrl readback plain");
    frame(0, 2'b01, 5'd2, 5'd0, 16'hFFFF, "R3 foreign write");
    frame(0, 2'b10, strap, 5'd0, 16'h0, "R3 R11 ctrl untouched by foreign write");

    pulse_cycles(4);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule